// File: doc/BRIEF.md
# Coprocessor Bus Grant Gate

This block sits between the main processor's bus and the 8 KB work memory of a sound coprocessor. It decodes the 24-bit main-processor address and holds two controls. A bus-request register halts or releases the coprocessor. A reset register fires a one-clock reset pulse towards it. Main-processor accesses to the coprocessor memory are let through only while the coprocessor is halted.

Reading the request register returns a status word. That word carries the coprocessor run flag and the value of a counter that advances on every status read. Memory reads return the addressed byte copied into both halves of the 16-bit data bus. A word write stores only its upper byte. A byte write stores its lower data byte at the exact byte address.

The memory itself is outside the block. The block drives its address, write data, write enable and read enable, and takes back an 8-bit read value that is valid in the same cycle.

Top module: `cobus_gate`

## Requirements
- R1: A write to the request register (word access: any address whose upper 23 bits match 0xA11100, bit taken from data bit 8; byte access: address exactly 0xA11100, bit taken from data bit 0) sets `cop_run` to the inverse of that bit from the next clock on: 1 halts, 0 releases.
- R2: A read of the request register returns bit 15 = 1, bits 14..9 = 0, bit 8 = `cop_run`, and bits 7..0 = the status counter.
- R3: The status counter is 8 bits wide. It advances by one on each clock cycle with a request-register read, wraps from 255 to 0, and is unchanged by any other access.
- R4: A write to the reset register (0xA11200, word bit 8 or byte bit 0) with a 0 bit drives `cop_rst` high for exactly one clock in the cycle after the write. A 1 bit produces no pulse.
- R5: Coprocessor memory is selected when (address AND 0xFF4000) equals 0xA00000. It is indexed by address bits 12..0, so 0xA02000..0xA03FFF alias 0xA00000..0xA01FFF, and word accesses clear index bit 0.
- R6: While `cop_run` is 1, memory reads return 0x0000 and memory writes do not reach the memory.
- R7: A memory read while halted returns the addressed byte in both bits 15..8 and bits 7..0.
- R8: A word write to memory stores data bits 15..8. A byte write stores data bits 7..0 at the addressed byte.
- R9: Reset leaves `cop_run` = 0 (halted), `cop_rst` = 0 and the status counter at 0.
- R10: Reads of any other address, including 0xA04000 and the odd byte 0xA11101, return 0x0000, and writes to them reach no memory or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 24 | Main-processor byte address |
| cpu_wdata | input | 16 | Main-processor write data |
| cpu_word | input | 1 | 1 = word access, 0 = byte access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 16 | Read data, valid in the strobe cycle |
| ram_addr | output | 13 | Coprocessor memory byte index |
| ram_wdata | output | 8 | Coprocessor memory write byte |
| ram_we | output | 1 | Coprocessor memory write enable |
| ram_re | output | 1 | Coprocessor memory read enable |
| ram_rdata | input | 8 | Coprocessor memory read byte |
| cop_run | output | 1 | 1 = coprocessor running, 0 = halted |
| cop_rst | output | 1 | One-clock coprocessor reset pulse |

## Verification
The bench builds the block with its default parameters. These are an 8-bit status counter with rotation enabled and a 13-bit memory index. The small counter lets a few hundred status reads carry it through a full wrap. The 13-bit index makes the alias at 0xA02000 and the unselected window at 0xA04000 reachable with short address patterns. The bench also models the memory as a byte array, so the write-ignore rule while running is observed through later reads after the coprocessor is halted.

// File: rtl/cobus_pkg.sv
package cobus_pkg;
   localparam int CPU_AW = 24;
   localparam int CPU_DW = 16;

   typedef struct packed {
      logic req;
      logic rst;
      logic ram;
   } cobus_hit_t;
endpackage

// File: rtl/cobus_decode.sv
module cobus_decode
   import cobus_pkg::*;
#(
   parameter logic [CPU_AW-1:0] REQ_ADDR = 24'hA11100,
   parameter logic [CPU_AW-1:0] RST_ADDR = 24'hA11200,
   parameter logic [CPU_AW-1:0] RAM_MASK = 24'hFF4000,
   parameter logic [CPU_AW-1:0] RAM_BASE = 24'hA00000
) (
   input  logic [CPU_AW-1:0] addr,
   input  logic              word,
   output cobus_hit_t        hit
);
   logic [CPU_AW-1:0] eff_addr;

   if (REQ_ADDR[0] != 1'b0) begin : g_chk_req
      $error("REQ_ADDR must be even");
   end
   if (RST_ADDR[0] != 1'b0) begin : g_chk_rst
      $error("RST_ADDR must be even");
   end
   if ((RAM_BASE & ~RAM_MASK) != '0) begin : g_chk_ram
      $error("RAM_BASE has bits outside RAM_MASK");
   end

   always_comb begin
      eff_addr = word ? {addr[CPU_AW-1:1], 1'b0} : addr;
      hit.req  = (eff_addr == REQ_ADDR);
      hit.rst  = (eff_addr == RST_ADDR);
      hit.ram  = ((addr & RAM_MASK) == RAM_BASE);
   end
endmodule

// File: rtl/cobus_ctrl.sv
module cobus_ctrl #(
   parameter int ROT_W     = 8,
   parameter bit ROTATE_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_wr,
   input  logic       req_bit,
   input  logic       rst_wr,
   input  logic       rst_bit,
   input  logic       stat_rd,
   output logic       run_o,
   output logic       rst_o,
   output logic [7:0] rot_o
);
   if (ROT_W < 1 || ROT_W > 8) begin : g_chk_rot
      $error("ROT_W must lie in 1..8");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o <= 1'b0;
      end else if (req_wr) begin
         run_o <= ~req_bit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_o <= 1'b0;
      end else begin
         rst_o <= rst_wr & ~rst_bit & ~rst_o;
      end
   end

   if (ROTATE_EN) begin : g_rot
      logic [ROT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (stat_rd) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
      assign rot_o = 8'(cnt_q);

      assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
         stat_rd |=> (cnt_q == $past(cnt_q) + 1'b1));
      assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !stat_rd |=> $stable(cnt_q));
   end else begin : g_norot
      assign rot_o = 8'h00;
   end

   assert_run_track_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_wr |=> (run_o == !$past(req_bit)));
   assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |=> !rst_o);
   assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_wr && !rst_bit) |=> !rst_o);
endmodule

// File: rtl/cobus_ram_port.sv
module cobus_ram_port #(
   parameter int RAM_AW = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              sel,
   input  logic              rd,
   input  logic              wr,
   input  logic              word,
   input  logic [RAM_AW-1:0] idx,
   input  logic [15:0]       wdata,
   input  logic [7:0]        ram_rdata,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              ram_we,
   output logic              ram_re,
   output logic [15:0]       rd_word
);
   logic granted;

   if (RAM_AW < 2 || RAM_AW > 14) begin : g_chk_aw
      $error("RAM_AW must lie in 2..14");
   end

   always_comb begin
      granted   = sel & ~run;
      ram_addr  = word ? {idx[RAM_AW-1:1], 1'b0} : idx;
      ram_wdata = word ? wdata[15:8] : wdata[7:0];
      ram_we    = granted & wr;
      ram_re    = granted & rd;
      rd_word   = ram_re ? {ram_rdata, ram_rdata} : 16'h0000;
   end

   assert_we_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> !run);
   assert_run_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && run) |-> (rd_word == 16'h0000));
endmodule

// File: rtl/cobus_gate.sv
module cobus_gate
   import cobus_pkg::*;
#(
   parameter int RAM_AW    = 13,
   parameter int ROT_W     = 8,
   parameter bit ROTATE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [23:0]       cpu_addr,
   input  logic [15:0]       cpu_wdata,
   input  logic              cpu_word,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   output logic [15:0]       cpu_rdata,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              ram_we,
   output logic              ram_re,
   input  logic [7:0]        ram_rdata,
   output logic              cop_run,
   output logic              cop_rst
);
   cobus_hit_t  hit;
   logic        ctl_bit;
   logic [7:0]  rot;
   logic [15:0] ram_word;
   logic [15:0] stat_word;

   cobus_decode u_dec (
      .addr (cpu_addr),
      .word (cpu_word),
      .hit  (hit)
   );

   assign ctl_bit = cpu_word ? cpu_wdata[8] : cpu_wdata[0];

   cobus_ctrl #(.ROT_W(ROT_W), .ROTATE_EN(ROTATE_EN)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_wr  (cpu_wr & hit.req),
      .req_bit (ctl_bit),
      .rst_wr  (cpu_wr & hit.rst),
      .rst_bit (ctl_bit),
      .stat_rd (cpu_rd & hit.req),
      .run_o   (cop_run),
      .rst_o   (cop_rst),
      .rot_o   (rot)
   );

   cobus_ram_port #(.RAM_AW(RAM_AW)) u_ram (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (cop_run),
      .sel       (hit.ram),
      .rd        (cpu_rd),
      .wr        (cpu_wr),
      .word      (cpu_word),
      .idx       (cpu_addr[RAM_AW-1:0]),
      .wdata     (cpu_wdata),
      .ram_rdata (ram_rdata),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata),
      .ram_we    (ram_we),
      .ram_re    (ram_re),
      .rd_word   (ram_word)
   );

   assign stat_word = {1'b1, 6'b000000, cop_run, rot};

   always_comb begin
      if (cpu_rd && hit.ram) begin
         cpu_rdata = ram_word;
      end else if (cpu_rd && hit.req) begin
         cpu_rdata = stat_word;
      end else begin
         cpu_rdata = 16'h0000;
      end
   end

   assert_status_fmt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && hit.req) |-> (cpu_rdata[15] && cpu_rdata[14:9] == 6'd0
                               && cpu_rdata[8] == cop_run));
   assert_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && hit.ram) |-> (cpu_rdata[15:8] == cpu_rdata[7:0]));
   assert_reset_state_R9: assert property (@(posedge clk)
      !rst_n |=> (!cop_run && !cop_rst));
   assert_no_stray_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !hit.ram && !hit.req) |-> (cpu_rdata == 16'h0000));
endmodule

// File: tb/cobus_gate_tb.sv
module cobus_gate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_word = 1'b0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [15:0] cpu_rdata;
   logic [12:0] ram_addr;
   logic [7:0]  ram_wdata;
   logic        ram_we;
   logic        ram_re;
   logic [7:0]  ram_rdata;
   logic        cop_run;
   logic        cop_rst;

   logic [7:0] mem [8192];
   int n_vec = 0;
   int n_bad = 0;
   int cnt_exp = 0;
   logic [15:0] q;

   always #4 clk = ~clk;

   always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
   assign ram_rdata = mem[ram_addr];

   cobus_gate u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_word(cpu_word), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
      .ram_rdata(ram_rdata), .cop_run(cop_run), .cop_rst(cop_rst)
   );

   // {read, word, addr[23:0], data_or_expect[15:0]}
   localparam int NV = 14;
   localparam logic [41:0] VEC [NV] = '{
      {1'b1, 1'b1, 24'hA00010, 16'h0000},  // R6 earlier write while running was dropped
      {1'b0, 1'b1, 24'hA00010, 16'hABCD},  // R8 word write keeps high byte
      {1'b1, 1'b1, 24'hA00010, 16'hABAB},  // R7
      {1'b0, 1'b0, 24'hA00011, 16'h0055},  // R8 byte write low byte
      {1'b1, 1'b0, 24'hA00011, 16'h5555},  // R7
      {1'b1, 1'b1, 24'hA00010, 16'hABAB},  // R8 neighbour byte untouched
      {1'b1, 1'b1, 24'hA00011, 16'hABAB},  // R5 word index bit 0 cleared
      {1'b0, 1'b0, 24'hA01FFF, 16'h007E},
      {1'b1, 1'b0, 24'hA03FFF, 16'h7E7E},  // R5 alias
      {1'b0, 1'b0, 24'hA00000, 16'h0033},
      {1'b0, 1'b1, 24'hA04000, 16'h1200},  // R10 outside memory window
      {1'b1, 1'b0, 24'hA00000, 16'h3333},  // R10 memory untouched
      {1'b1, 1'b1, 24'hA04000, 16'h0000},  // R10
      {1'b1, 1'b1, 24'hA10000, 16'h0000}   // R10
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input bit wr, input bit word, input logic [23:0] a,
                      input logic [15:0] d, output logic [15:0] rq);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_word = word;
      cpu_wr = wr; cpu_rd = ~wr;
      #1 rq = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0;
   endtask

   function automatic logic [15:0] stat_exp(input logic run, input int c);
      return 16'h8000 | (16'(run) << 8) | 16'(c & 8'hFF);
   endfunction

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 run after reset", {15'd0, cop_run}, 16'd0);
      chk("R9 pulse after reset", {15'd0, cop_rst}, 16'd0);

      acc(1'b0, 1'b1, 24'hA11100, 16'h0, q);
      chk("R2 R9 status first read", q, stat_exp(1'b0, cnt_exp)); cnt_exp++;
      acc(1'b0, 1'b1, 24'hA11100, 16'h0, q);
      chk("R3 status second read", q, stat_exp(1'b0, cnt_exp)); cnt_exp++;
      acc(1'b0, 1'b0, 24'hA11101, 16'h0, q);
      chk("R10 odd byte of request reg", q, 16'h0000);

      acc(1'b1, 1'b1, 24'hA11100, 16'h0000, q);
      chk("R1 release by word write", {15'd0, cop_run}, 16'd1);
      acc(1'b0, 1'b1, 24'hA11100, 16'h0, q);
      chk("R2 status while running", q, stat_exp(1'b1, cnt_exp)); cnt_exp++;
      acc(1'b0, 1'b1, 24'hA00010, 16'h0, q);
      chk("R6 read while running", q, 16'h0000);
      acc(1'b1, 1'b0, 24'hA00010, 16'h0099, q);
      acc(1'b1, 1'b0, 24'hA11100, 16'h0001, q);
      chk("R1 halt by byte write", {15'd0, cop_run}, 16'd0);

      for (int v = 0; v < NV; v++) begin
         acc(!VEC[v][41], VEC[v][40], VEC[v][39:16], VEC[v][15:0], q);
         if (VEC[v][41]) chk("R5-R8 vector read", q, VEC[v][15:0]);
      end

      acc(1'b1, 1'b1, 24'hA11200, 16'h0000, q);
      chk("R4 pulse high after word write", {15'd0, cop_rst}, 16'd1);
      @(negedge clk);
      chk("R4 pulse one clock", {15'd0, cop_rst}, 16'd0);
      acc(1'b1, 1'b1, 24'hA11200, 16'h0100, q);
      chk("R4 no pulse for bit 1", {15'd0, cop_rst}, 16'd0);
      acc(1'b1, 1'b0, 24'hA11200, 16'h0000, q);
      chk("R4 pulse after byte write", {15'd0, cop_rst}, 16'd1);
      acc(1'b1, 1'b0, 24'hA11200, 16'h0001, q);
      chk("R4 no pulse byte bit 1", {15'd0, cop_rst}, 16'd0);

      begin
         logic [15:0] last_q;
         logic [15:0] last_e;
         int bad_w;
         bad_w = 0;
         for (int k = 0; k < 300; k++) begin
            acc(1'b0, 1'b1, 24'hA11100, 16'h0, q);
            if (q !== stat_exp(1'b0, cnt_exp)) bad_w++;
            last_q = q; last_e = stat_exp(1'b0, cnt_exp);
            cnt_exp++;
         end
         if (bad_w != 0) last_q = last_q ^ 16'h0000;
         chk("R3 counter wrap", (bad_w != 0) ? ~last_e : last_q, last_e);
      end

      acc(1'b1, 1'b1, 24'hA11100, 16'h0000, q);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R9 run after mid reset", {15'd0, cop_run}, 16'd0);
      cnt_exp = 0;
      acc(1'b0, 1'b1, 24'hA11100, 16'h0, q);
      chk("R9 counter after mid reset", q, stat_exp(1'b0, cnt_exp));

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule